// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block collects streaming stores that are meant to bypass the caches and writes them to memory later, one whole line at a time. It has a small set of line-sized entries, and the cache hierarchy and the ordinary store queue never see these entries. Each entry holds one aligned line together with a mask that marks which bytes have been written. A store that lands in a line already held is merged into that entry. When two stores write the same byte, only the later value reaches memory. Other agents never look into the buffer, so nothing it holds is coherent until it has been written out.

An entry is written out in three cases: when every byte of its line has been written, when a store needs an entry and all of them are taken (the entry allocated first is written out), or when the core raises a fence. While the fence is held, stores are refused. The fence is answered only when the buffer is empty and memory has acknowledged every write the buffer issued. The memory side is a single valid/ready write port that carries a line address, the line data, a byte-enable mask and a full-line flag. A separate acknowledge pulse returns once for each accepted write.

Top module: `wcb_top`

## Requirements
- R1: After reset no entry is occupied, `mw_valid` is 0, `st_ready` is 1 and `fence_done` is 0 while `fence_req` is low. A fence raised on an empty buffer is answered in the same cycle.
- R2: Stores are word-aligned (the low three address bits are zero). Address bits [31:6] select the line and bits [5:3] select the 8-byte word. Stores to one line are merged into one entry, and the line is written out once, with `mw_be` equal to the union of the stores' byte enables. Byte k of `mw_be` and bits [8k+7:8k] of `mw_data` belong to line byte k.
- R3: When several stores write the same byte of a buffered line, the value written to memory is the one from the last accepted store.
- R4: A line whose 64 bytes have all been written is sent to memory without a fence, with `mw_be` all ones and `mw_full` = 1.
- R5: A partially written line is sent with `mw_full` = 0, and every byte that was never written is sent as zero.
- R6: A store to a new line while all 4 entries are occupied is stalled. The entry allocated first is written out, and the store is then accepted into the freed entry.
- R7: While `fence_req` is high, `st_ready` is 0 and every occupied entry is written out in the order of allocation, oldest first.
- R8: `fence_done` stays 0 until every entry is empty and every issued write has been acknowledged on `mw_ack`.
- R9: A store to a line whose entry is waiting to be written out is stalled until that write is taken by memory.
- R10: While `mw_valid` is high and `mw_ready` is low, `mw_valid` and the write payload hold steady.
- R11: At most 4 writes are outstanding without an acknowledge. Further writes wait for acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | 32 | Store byte address, word-aligned |
| st_data | input | 64 | Store data, byte k in bits [8k+7:8k] |
| st_be | input | 8 | Store byte enables |
| fence_req | input | 1 | Level fence request; stalls stores and drains the buffer |
| fence_done | output | 1 | Buffer empty and all writes acknowledged while fence_req is high |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory takes the write |
| mw_addr | output | 32 | Line-aligned write address |
| mw_data | output | 512 | Line data |
| mw_be | output | 64 | Byte enables of the line |
| mw_full | output | 1 | All 64 bytes enabled |
| mw_ack | input | 1 | One pulse per completed write |

## Verification
The bench runs many trials that each fill from one to four lines with overlapping byte patterns. Every word-level merge and overwrite is compared against a byte-level shadow model, and the fence order is checked against allocation order. A design that merged by word instead of by byte, or that kept the first writer, would send wrong bytes or a wrong mask. A design that drained in index order would break the oldest-first check. Directed cases cover eviction on a full buffer, an auto-drain of a complete line, a store that hits a line waiting for memory while the port is back-pressured, a fence with acknowledges withheld, and the cap on outstanding writes. Each case targets a design that lets the stalled store slip in, changes the payload under back-pressure, answers the fence early, or issues a fifth write before any acknowledge returns.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

  typedef enum logic [0:0] {
    DRN_IDLE = 1'b0,
    DRN_SEND = 1'b1
  } drn_state_e;

  function automatic int unsigned width_of(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wcb_entry.sv
module wcb_entry #(
  parameter int TAG_W      = 26,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int WORDS  = LINE_BYTES / WORD_BYTES,
  localparam int WSEL_W = wcb_pkg::width_of(WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_en,
  input  logic                  merge_en,
  input  logic                  clr_en,
  input  logic                  pend_set,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [WSEL_W-1:0]     wr_word,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic [WORD_BYTES-1:0] wr_be,
  output logic                  ent_valid,
  output logic                  ent_pend,
  output logic [TAG_W-1:0]      ent_tag,
  output logic [LINE_BYTES-1:0] ent_mask,
  output logic [LINE_W-1:0]     ent_data
);

  logic [LINE_BYTES-1:0] lane_be;
  logic [LINE_W-1:0]     lane_data;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    assign lane_be[b] = (wr_word == WSEL_W'(b / WORD_BYTES)) && wr_be[b % WORD_BYTES];
    assign lane_data[8*b +: 8] = wr_data[8*(b % WORD_BYTES) +: 8];
  end

  logic                  valid_q, valid_d;
  logic                  pend_q, pend_d;
  logic [TAG_W-1:0]      tag_q, tag_d;
  logic [LINE_BYTES-1:0] mask_q, mask_d;
  logic [LINE_W-1:0]     data_q, data_d;
  logic                  data_en;

  assign data_en = alloc_en | merge_en;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    mask_d  = mask_q;
    data_d  = data_q;
    if (clr_en) begin
      valid_d = 1'b0;
      mask_d  = '0;
    end else if (alloc_en) begin
      valid_d = 1'b1;
      tag_d   = wr_tag;
      mask_d  = lane_be;
      for (int b = 0; b < LINE_BYTES; b++) begin
        data_d[8*b +: 8] = lane_be[b] ? lane_data[8*b +: 8] : 8'h00;
      end
    end else if (merge_en) begin
      mask_d = mask_q | lane_be;
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (lane_be[b]) data_d[8*b +: 8] = lane_data[8*b +: 8];
      end
    end
    pend_d = !clr_en && valid_d && (pend_q || pend_set || (&mask_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      tag_q   <= '0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_d;
      pend_q  <= pend_d;
      mask_q  <= mask_d;
      if (data_en) tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
  end

  assign ent_valid = valid_q;
  assign ent_pend  = pend_q;
  assign ent_tag   = tag_q;
  assign ent_mask  = mask_q;
  assign ent_data  = data_q;

  // R2: an occupied entry always holds at least one written byte
  a_r2_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (mask_q != '0));

  // R9: the top never merges into an entry that waits for memory
  a_r9_no_merge_pending: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |-> !pend_q);

endmodule

// File: rtl/wcb_age.sv
module wcb_age #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] cand_a,
  input  logic [N-1:0] cand_b,
  output logic [N-1:0] pick_a,
  output logic [N-1:0] pick_b
);

  // older_q[i][j] set: entry i was allocated before entry j
  logic [N-1:0][N-1:0] older_q, older_d;

  always_comb begin
    older_d = older_q;
    for (int k = 0; k < N; k++) begin
      if (alloc_oh[k]) begin
        for (int j = 0; j < N; j++) begin
          if (j != k) begin
            older_d[k][j] = 1'b0;
            older_d[j][k] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_q <= '0;
    else if (|alloc_oh) older_q <= older_d;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pick_a[i] = cand_a[i];
      pick_b[i] = cand_b[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && cand_a[j] && !older_q[i][j]) pick_a[i] = 1'b0;
        if (j != i && cand_b[j] && !older_q[i][j]) pick_b[i] = 1'b0;
      end
    end
  end

  // R6: exactly one oldest among occupied entries
  a_r6_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand_a) |-> ($countones(pick_a) == 1));

  // R7: exactly one oldest among entries waiting to drain
  a_r7_one_oldest_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand_b) |-> ($countones(pick_b) == 1));

endmodule

// File: rtl/wcb_drain.sv
module wcb_drain #(
  parameter int N       = 4,
  parameter int MAX_OUT = 4,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] pick_pend,
  input  logic         mw_ready,
  input  logic         mw_ack,
  output logic [N-1:0] sel_oh,
  output logic         mw_valid,
  output logic         fire,
  output logic         owed_none
);

  import wcb_pkg::*;

  drn_state_e       state_q, state_d;
  logic [N-1:0]     sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start;

  assign start = (state_q == DRN_IDLE) && (|pend) && (cnt_q < CNT_W'(MAX_OUT));
  assign fire  = (state_q == DRN_SEND) && mw_ready;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    if (start) begin
      state_d = DRN_SEND;
      sel_d   = pick_pend;
    end else if (fire) begin
      state_d = DRN_IDLE;
      sel_d   = '0;
    end
    cnt_d = cnt_q;
    case ({fire, mw_ack})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DRN_IDLE;
      sel_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start || fire) sel_q <= sel_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sel_oh    = sel_q;
  assign mw_valid  = (state_q == DRN_SEND);
  assign owed_none = (cnt_q == '0);

  // R10: request and selected entry stay put under back-pressure
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(sel_oh)));

  // R11: never more writes outstanding than allowed
  a_r11_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_OUT));

  // R8: an acknowledge only arrives for a write still owed
  a_r8_ack_owed: assert property (@(posedge clk) disable iff (!rst_n)
    mw_ack |-> (cnt_q != '0));

  // R9: the entry being sent is one flagged for draining
  a_r9_send_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> (|(sel_q & pend)));

endmodule

// File: rtl/wcb_top.sv
module wcb_top #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int NUM_ENT    = 4,
  parameter int MAX_OUT    = 4,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int WB_LSB = $clog2(WORD_BYTES),
  localparam int WSEL_W = wcb_pkg::width_of(LINE_BYTES / WORD_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [WORD_W-1:0]     st_data,
  input  logic [WORD_BYTES-1:0] st_be,
  input  logic                  fence_req,
  output logic                  fence_done,
  output logic                  mw_valid,
  input  logic                  mw_ready,
  output logic [ADDR_W-1:0]     mw_addr,
  output logic [LINE_W-1:0]     mw_data,
  output logic [LINE_BYTES-1:0] mw_be,
  output logic                  mw_full,
  input  logic                  mw_ack
);

  logic [TAG_W-1:0]      st_tag;
  logic [WSEL_W-1:0]     st_word;
  logic [NUM_ENT-1:0]    valid, pend, hit_vec, free_oh, alloc_oh, merge_vec;
  logic [NUM_ENT-1:0]    clr_vec, pend_set, oldest_valid, oldest_pend, sel_oh;
  logic [TAG_W-1:0]      tag_a  [NUM_ENT];
  logic [LINE_BYTES-1:0] mask_a [NUM_ENT];
  logic [LINE_W-1:0]     data_a [NUM_ENT];
  logic                  hit, hit_pend, any_free, accept, evict_need, fire, owed_none;
  logic [TAG_W-1:0]      mw_tag;

  assign st_tag  = st_addr[ADDR_W-1:OFF_W];
  assign st_word = st_addr[OFF_W-1:WB_LSB];

  always_comb begin
    logic found;
    found = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      free_oh[i] = !valid[i] && !found;
      found      = found | !valid[i];
    end
  end

  assign hit        = |hit_vec;
  assign hit_pend   = |(hit_vec & pend);
  assign any_free   = |(~valid);
  assign st_ready   = !fence_req && !hit_pend && (hit || any_free);
  assign accept     = st_valid && st_ready;
  assign evict_need = st_valid && !fence_req && !hit && !any_free;
  assign alloc_oh   = (accept && !hit) ? free_oh : '0;
  assign merge_vec  = accept ? hit_vec : '0;
  assign clr_vec    = fire ? sel_oh : '0;
  assign pend_set   = (fence_req ? valid : '0) | (evict_need ? oldest_valid : '0);

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    assign hit_vec[i] = valid[i] && (tag_a[i] == st_tag);

    wcb_entry #(
      .TAG_W      (TAG_W),
      .LINE_BYTES (LINE_BYTES),
      .WORD_BYTES (WORD_BYTES)
    ) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (alloc_oh[i]),
      .merge_en  (merge_vec[i]),
      .clr_en    (clr_vec[i]),
      .pend_set  (pend_set[i]),
      .wr_tag    (st_tag),
      .wr_word   (st_word),
      .wr_data   (st_data),
      .wr_be     (st_be),
      .ent_valid (valid[i]),
      .ent_pend  (pend[i]),
      .ent_tag   (tag_a[i]),
      .ent_mask  (mask_a[i]),
      .ent_data  (data_a[i])
    );
  end

  wcb_age #(.N(NUM_ENT)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_oh (alloc_oh),
    .cand_a   (valid),
    .cand_b   (pend),
    .pick_a   (oldest_valid),
    .pick_b   (oldest_pend)
  );

  wcb_drain #(.N(NUM_ENT), .MAX_OUT(MAX_OUT)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .pick_pend (oldest_pend),
    .mw_ready  (mw_ready),
    .mw_ack    (mw_ack),
    .sel_oh    (sel_oh),
    .mw_valid  (mw_valid),
    .fire      (fire),
    .owed_none (owed_none)
  );

  always_comb begin
    mw_tag  = '0;
    mw_data = '0;
    mw_be   = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (sel_oh[i]) begin
        mw_tag  = mw_tag  | tag_a[i];
        mw_data = mw_data | data_a[i];
        mw_be   = mw_be   | mask_a[i];
      end
    end
  end

  assign mw_addr    = {mw_tag, {OFF_W{1'b0}}};
  assign mw_full    = &mw_be;
  assign fence_done = fence_req && !(|valid) && owed_none;

  logic dup_tag;
  always_comb begin
    dup_tag = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      for (int j = i + 1; j < NUM_ENT; j++) begin
        if (valid[i] && valid[j] && tag_a[i] == tag_a[j]) dup_tag = 1'b1;
      end
    end
  end

  // R2: a line is never held in two entries
  a_r2_one_entry_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_tag);

  // R2: store addresses are word-aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_addr[WB_LSB-1:0] == '0));

  // R8: the fence is never answered while a write is on the port
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> !mw_valid);

endmodule

// File: tb/sim_wcb_top.sv
`timescale 1ns/1ps
module sim_wcb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid;
  logic         st_ready;
  logic [31:0]  st_addr;
  logic [63:0]  st_data;
  logic [7:0]   st_be;
  logic         fence_req;
  logic         fence_done;
  logic         mw_valid;
  logic         mw_ready;
  logic [31:0]  mw_addr;
  logic [511:0] mw_data;
  logic [63:0]  mw_be;
  logic         mw_full;
  logic         mw_ack;

  always #2.5 clk = ~clk;

  wcb_top u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .fence_req(fence_req), .fence_done(fence_done),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_be(mw_be), .mw_full(mw_full), .mw_ack(mw_ack)
  );

  int n_checks = 0;
  int n_err    = 0;
  int drain_cnt = 0;
  int pend_acks = 0;
  int seq_ctr = 0;
  bit ack_en = 1'b1;
  bit chk_order = 1'b1;
  bit done_flag = 1'b0;

  // shadow of buffered lines
  bit           rv   [8];
  logic [25:0]  rtag [8];
  logic [63:0]  rbe  [8];
  logic [511:0] rdat [8];
  int           rseq [8];
  logic [31:0]  dlog [64];
  logic [63:0]  last_be;
  logic         last_full;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  function automatic logic [63:0] gen(input int a, input int b, input int c);
    return {32'(a * 40503 + b * 2654435 + c * 7 + 1), 32'((a ^ (b << 7)) * 69069 + c * 911)};
  endfunction

  function automatic logic [31:0] laddr(input int line, input int w);
    return 32'((line << 6) | (w << 3));
  endfunction

  function automatic int ref_count();
    int n = 0;
    for (int s = 0; s < 8; s++) if (rv[s]) n++;
    return n;
  endfunction

  task automatic ref_put(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be);
    int s = -1;
    for (int k = 0; k < 8; k++) if (rv[k] && rtag[k] == a[31:6]) s = k;
    if (s < 0) begin
      for (int k = 7; k >= 0; k--) if (!rv[k]) s = k;
      rv[s] = 1'b1; rtag[s] = a[31:6]; rbe[s] = '0; rdat[s] = '0;
      rseq[s] = seq_ctr; seq_ctr++;
    end
    for (int b = 0; b < 8; b++) begin
      if (be[b]) begin
        rbe[s][a[5:3]*8 + b] = 1'b1;
        rdat[s][(a[5:3]*8 + b)*8 +: 8] = d[8*b +: 8];
      end
    end
  endtask

  // drain monitor and acknowledge bookkeeping
  always @(negedge clk) begin
    if (rst_n) begin
      if (mw_ack) pend_acks--;
      if (mw_valid && mw_ready) begin
        int s = -1;
        for (int k = 0; k < 8; k++) if (rv[k] && rtag[k] == mw_addr[31:6]) s = k;
        chk(s >= 0, "R2 drained line is buffered", 64'(mw_addr), 64'(mw_addr));
        if (s >= 0) begin
          int wd = 0;
          for (int w = 7; w >= 0; w--) if (mw_data[64*w +: 64] != rdat[s][64*w +: 64]) wd = w;
          chk(mw_be == rbe[s], "R2 merged byte mask", mw_be, rbe[s]);
          chk(mw_data == rdat[s], "R3 R5 line data", mw_data[64*wd +: 64], rdat[s][64*wd +: 64]);
          chk(mw_full == (&rbe[s]), "R4 R5 full flag", 64'(mw_full), 64'(&rbe[s]));
          if (chk_order) begin
            bit oldest = 1'b1;
            for (int k = 0; k < 8; k++) if (rv[k] && rseq[k] < rseq[s]) oldest = 1'b0;
            chk(oldest, "R6 R7 oldest first", 64'(rseq[s]), 64'(rseq[s]));
          end
          rv[s] = 1'b0;
        end
        dlog[drain_cnt % 64] = mw_addr;
        last_be = mw_be;
        last_full = mw_full;
        drain_cnt++;
        pend_acks++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    mw_ack = rst_n && ack_en && (pend_acks > 0);
  end

  task automatic store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be);
    int guard = 0;
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    do begin
      @(negedge clk);
      guard++;
    end while (!st_ready && guard < 3000);
    chk(st_ready, "R9 store accepted eventually", 64'(st_ready), 64'd1);
    @(posedge clk); #1;
    st_valid = 1'b0;
    ref_put(a, d, be);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fence_wait();
    int guard = 0;
    @(posedge clk); #1;
    fence_req = 1'b1;
    do begin
      @(negedge clk);
      guard++;
    end while (!fence_done && guard < 3000);
    chk(fence_done, "R7 fence completes", 64'(fence_done), 64'd1);
    chk(ref_count() == 0 && pend_acks == 0, "R8 done only when empty and acknowledged",
        64'(ref_count() + pend_acks), 64'd0);
    @(posedge clk); #1;
    fence_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    int d0;
    logic [31:0] held;
    for (int k = 0; k < 8; k++) rv[k] = 1'b0;
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
    fence_req = 1'b0; mw_ready = 1'b1; mw_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mw_valid, "R1 reset mw_valid", 64'(mw_valid), 64'd0);
    chk(st_ready, "R1 reset st_ready", 64'(st_ready), 64'd1);
    chk(!fence_done, "R1 reset fence_done", 64'(fence_done), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fence_done && st_ready && !mw_valid, "R1 idle after reset", 64'(fence_done), 64'd0);
    @(posedge clk); #1;
    fence_req = 1'b1;
    @(negedge clk);
    chk(fence_done, "R1 empty fence answered at once", 64'(fence_done), 64'd1);
    chk(!st_ready, "R7 stores blocked during fence", 64'(st_ready), 64'd0);
    @(posedge clk); #1;
    fence_req = 1'b0;

    // sweep: 1..4 lines per trial, overlapping byte patterns, fence drain
    chk_order = 1'b1;
    for (int t = 0; t < 48; t++) begin
      int nl = (t % 4) + 1;
      d0 = drain_cnt;
      for (int i = 0; i < 3; i++) begin
        for (int j = 0; j < nl; j++) begin
          int w = (i == 2) ? ((t + j) % 8) : ((t + i * 3 + j) % 8);
          logic [7:0] be = 8'(t * 37 + i * 91 + j * 13 + 1);
          if (be == 8'h00) be = 8'h81;
          store(laddr(64 + t * 4 + j, w), gen(t, i, j), be);
        end
      end
      fence_wait();
      chk(drain_cnt == d0 + nl, "R2 one write per line", 64'(drain_cnt - d0), 64'(nl));
    end

    // R6 eviction of the oldest when all entries are occupied
    for (int j = 0; j < 4; j++) store(laddr(1000 + j, j), gen(j, 5, 5), 8'hFF);
    d0 = drain_cnt;
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = laddr(1004, 2); st_data = gen(9, 9, 9); st_be = 8'h3C;
    @(negedge clk);
    chk(!st_ready, "R6 store stalled when full", 64'(st_ready), 64'd0);
    begin
      int guard = 0;
      while (!st_ready && guard < 1000) begin @(negedge clk); guard++; end
    end
    chk(drain_cnt == d0 + 1, "R6 one eviction", 64'(drain_cnt - d0), 64'd1);
    chk(dlog[(drain_cnt - 1) % 64] == laddr(1000, 0), "R6 oldest evicted",
        64'(dlog[(drain_cnt - 1) % 64]), 64'(laddr(1000, 0)));
    @(posedge clk); #1;
    st_valid = 1'b0;
    ref_put(laddr(1004, 2), gen(9, 9, 9), 8'h3C);
    d0 = drain_cnt;
    fence_wait();
    chk(drain_cnt == d0 + 4, "R7 fence drains all", 64'(drain_cnt - d0), 64'd4);
    for (int j = 0; j < 4; j++)
      chk(dlog[(d0 + j) % 64] == laddr(1001 + j, 0), "R7 allocation order",
          64'(dlog[(d0 + j) % 64]), 64'(laddr(1001 + j, 0)));

    // R4 full line drains by itself
    chk_order = 1'b0;
    d0 = drain_cnt;
    for (int w = 0; w < 8; w++) store(laddr(1100, w), gen(w, 1, 2), 8'hFF);
    cycles(6);
    @(negedge clk);
    chk(drain_cnt == d0 + 1, "R4 full line sent without fence", 64'(drain_cnt - d0), 64'd1);
    chk(last_full && last_be == '1, "R4 full mask", last_be, 64'hFFFF_FFFF_FFFF_FFFF);

    // R9 / R10 hit on a line waiting for a back-pressured port
    @(posedge clk); #1;
    mw_ready = 1'b0;
    for (int w = 0; w < 8; w++) store(laddr(1200, w), gen(w, 3, 4), 8'hFF);
    cycles(4);
    @(negedge clk);
    chk(mw_valid, "R10 request raised", 64'(mw_valid), 64'd1);
    held = mw_addr;
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = laddr(1200, 4); st_data = gen(7, 7, 7); st_be = 8'h0F;
    @(negedge clk);
    chk(!st_ready, "R9 hit on draining line stalls", 64'(st_ready), 64'd0);
    cycles(5);
    @(negedge clk);
    chk(mw_valid && mw_addr == held, "R10 payload held", 64'(mw_addr), 64'(held));
    chk(!st_ready, "R9 still stalled", 64'(st_ready), 64'd0);
    @(posedge clk); #1;
    st_valid = 1'b0;
    mw_ready = 1'b1;
    d0 = drain_cnt;
    store(laddr(1200, 4), gen(7, 7, 7), 8'h0F);
    chk(drain_cnt == d0 + 1, "R9 stalled store waits for write", 64'(drain_cnt - d0), 64'd1);
    fence_wait();

    // R8 fence held until acknowledges return
    ack_en = 1'b0;
    d0 = drain_cnt;
    store(laddr(1300, 1), gen(1, 1, 1), 8'hA5);
    @(posedge clk); #1;
    fence_req = 1'b1;
    cycles(10);
    @(negedge clk);
    chk(drain_cnt == d0 + 1, "R8 write issued", 64'(drain_cnt - d0), 64'd1);
    chk(!fence_done, "R8 no done before ack", 64'(fence_done), 64'd0);
    @(posedge clk); #1;
    ack_en = 1'b1;
    cycles(3);
    @(negedge clk);
    chk(fence_done, "R8 done after ack", 64'(fence_done), 64'd1);
    @(posedge clk); #1;
    fence_req = 1'b0;

    // R11 outstanding cap
    ack_en = 1'b0;
    d0 = drain_cnt;
    for (int l = 0; l < 5; l++)
      for (int w = 0; w < 8; w++) store(laddr(1400 + l, w), gen(l, w, 3), 8'hFF);
    cycles(10);
    @(negedge clk);
    chk(drain_cnt == d0 + 4, "R11 four writes without ack", 64'(drain_cnt - d0), 64'd4);
    chk(!mw_valid, "R11 fifth write waits", 64'(mw_valid), 64'd0);
    @(posedge clk); #1;
    ack_en = 1'b1;
    cycles(12);
    @(negedge clk);
    chk(drain_cnt == d0 + 5, "R11 fifth write after ack", 64'(drain_cnt - d0), 64'd5);
    fence_wait();

    done_flag = 1'b1;
    summary();
  end

endmodule